// File: doc/BRIEF.md
# Next-Line Sequential Prefetcher

This block sits beside a first-level data cache and watches its demand traffic. Each demand access arrives as a block address, a hit/miss flag and a valid strobe. When the selected policy decides that the access deserves a lookahead, the block offers a request for the following block (address plus one) on a valid/ready output. The output register holds a single request. A newer request overwrites an older one that has not yet been accepted. Nothing is ever queued.

Two policies are available, chosen by a mode input. In miss-triggered mode (`mode_i = 0`), only demand misses start a lookahead. In tagged mode (`mode_i = 1`), the block keeps one flag bit per cache set, indexed by the low `SET_W` bits of the block address. A demand fill clears the flag. A fill of a prefetched line sets it. In tagged mode, a lookahead starts on every miss, and also on the first hit to a line whose flag is still set; that hit clears the flag. The cache reports fills on a separate strobe that carries a prefetch/demand marker.

The request register is a two-state machine. State `REQ_IDLE` means no request is offered. State `REQ_PEND` means a request is offered on `pf_blk_o`. The transitions are:
- issue: `REQ_IDLE` to `REQ_PEND` when a new candidate arrives.
- replace: `REQ_PEND` to `REQ_PEND` when a new, different candidate arrives.
- hold: `REQ_PEND` to `REQ_PEND` when the output is stalled and no candidate arrives.
- drain: `REQ_PEND` to `REQ_IDLE` when the request is accepted and no new candidate arrives.

Top module: `opf_top`

## Requirements
- R1: After reset, `pf_valid_o` is 0 and every tag flag is 0, so a tagged-mode hit starts no lookahead until a prefetch fill has set the flag of its set.
- R2: With `mode_i = 0`, an access with `acc_hit_i = 0` to block b makes `pf_valid_o` = 1 and `pf_blk_o` = b+1 in the cycle after the access. An access with `acc_hit_i = 1` starts nothing.
- R3: With `mode_i = 1`, an access with `acc_hit_i = 0` to block b starts a lookahead to b+1 in the next cycle, whatever the value of the flag.
- R4: With `mode_i = 1`, a hit to block b whose set flag is 1 starts a lookahead to b+1 in the next cycle and clears that flag. A second hit to that set therefore starts nothing.
- R5: With `mode_i = 1`, a hit to a set whose flag is 0 starts no lookahead.
- R6: A fill with `fill_pf_i = 1` sets the flag of set `fill_blk_i[SET_W-1:0]`. A fill with `fill_pf_i = 0` clears it. When a fill and a flag-clearing hit target the same set in the same cycle, the fill value wins. The access still reads the old flag.
- R7: While `pf_valid_o = 1` and `pf_ready_i = 0`, the offered block stays unchanged unless a new candidate arrives. A new, different candidate replaces it in the next cycle.
- R8: When `pf_valid_o` and `pf_ready_i` are both 1 and no new candidate arrives, `pf_valid_o` is 0 in the next cycle.
- R9: An access to the all-ones block address starts no lookahead in either mode. In tagged mode it still clears the flag.
- R10: A candidate equal to the block currently offered is dropped. It does not re-arm a request that is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = miss-triggered, 1 = tagged |
| acc_valid_i | input | 1 | Demand access strobe |
| acc_blk_i | input | ADDR_W | Block address of the demand access |
| acc_hit_i | input | 1 | 1 = access hit in the cache |
| fill_valid_i | input | 1 | Line fill strobe |
| fill_blk_i | input | ADDR_W | Block address of the filled line |
| fill_pf_i | input | 1 | 1 = fill came from a prefetch, 0 = demand fill |
| pf_valid_o | output | 1 | Prefetch request offered |
| pf_ready_i | input | 1 | Consumer accepts the offered request |
| pf_blk_o | output | ADDR_W | Block address to prefetch |

## Verification
Two kinds of internal error show up at the ports. A flag bit left in the wrong state shows one cycle after the next tagged-mode hit to that set: a lookahead appears or goes missing. A stuck or stale request state shows on `pf_valid_o` or `pf_blk_o` one cycle after the stimulus that should have moved it. The bench therefore runs a behavioural model next to the design and compares both outputs on every cycle. It also makes directed checks on:
- fill/hit collisions on the same set;
- the all-ones address;
- duplicate candidates during a stall and on acceptance.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic {
        POL_ON_MISS = 1'b0,
        POL_TAGGED  = 1'b1
    } opf_policy_e;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } opf_req_state_e;

endpackage

// File: rtl/opf_tag_bits.sv
module opf_tag_bits #(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_blk,
    input  logic              clr_en,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_blk,
    input  logic              fill_pf,
    output logic              rd_bit
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  flag_q;
    logic [SETS-1:0]  flag_d;
    logic [SET_W-1:0] acc_set;
    logic [SET_W-1:0] fill_set;

    assign acc_set  = acc_blk[SET_W-1:0];
    assign fill_set = fill_blk[SET_W-1:0];
    assign rd_bit   = flag_q[acc_set];

    // The clear is applied first, so a fill to the same set in the same cycle wins.
    always_comb begin
        flag_d = flag_q;
        if (clr_en) begin
            flag_d[acc_set] = 1'b0;
        end
        if (fill_en) begin
            flag_d[fill_set] = fill_pf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // R6
    fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (flag_q[$past(fill_set)] == $past(fill_pf)));

    // R4
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(fill_en && fill_set == acc_set)) |=> !flag_q[$past(acc_set)]);

endmodule

// File: rtl/opf_policy.sv
module opf_policy
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  opf_policy_e       policy,
    input  logic              acc_valid,
    input  logic              acc_hit,
    input  logic [ADDR_W-1:0] acc_blk,
    input  logic              tag_bit,
    output logic              fire,
    output logic [ADDR_W-1:0] cand_blk,
    output logic              clr_en
);
    logic want;
    logic at_top;

    assign at_top   = (acc_blk == {ADDR_W{1'b1}});
    assign cand_blk = acc_blk + {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        want   = 1'b0;
        clr_en = 1'b0;
        if (acc_valid) begin
            unique case (policy)
                POL_ON_MISS: want = !acc_hit;
                POL_TAGGED: begin
                    want   = !acc_hit || tag_bit;
                    clr_en = acc_hit && tag_bit;
                end
                default: want = 1'b0;
            endcase
        end
    end

    assign fire = want && !at_top;

    always_comb begin
        if (fire && policy == POL_ON_MISS) begin
            // R2
            miss_only_chk: assert (!acc_hit);
        end
        if (fire && policy == POL_TAGGED && acc_hit) begin
            // R5
            tagged_hit_flag_chk: assert (tag_bit);
        end
    end

endmodule

// File: rtl/opf_req_fsm.sv
module opf_req_fsm
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_blk,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] blk
);
    opf_req_state_e    state_q;
    opf_req_state_e    state_d;
    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] blk_d;
    logic              dup;
    logic              take;

    assign dup  = (state_q == REQ_PEND) && (load_blk == blk_q);
    assign take = load && !dup;

    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (take) begin
                    state_d = REQ_PEND;
                    blk_d   = load_blk;
                end
            end
            REQ_PEND: begin
                if (take) begin
                    blk_d = load_blk;
                end else if (ready) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    always_comb begin
        valid = (state_q == REQ_PEND);
        blk   = blk_q;
    end

    // R7
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !load) |=> (valid && $stable(blk)));

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !load) |=> !valid);

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (blk != '0));

    // R10
    dup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && load && load_blk == blk) |=> !valid);

    // R2
    issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(valid && load_blk == blk)) |=> (valid && blk == $past(load_blk)));

endmodule

// File: rtl/opf_top.sv
module opf_top
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_blk_i,
    input  logic              acc_hit_i,
    input  logic              fill_valid_i,
    input  logic [ADDR_W-1:0] fill_blk_i,
    input  logic              fill_pf_i,
    output logic              pf_valid_o,
    input  logic              pf_ready_i,
    output logic [ADDR_W-1:0] pf_blk_o
);
    opf_policy_e       policy;
    logic              tag_bit;
    logic              fire;
    logic              clr_en;
    logic [ADDR_W-1:0] cand_blk;

    assign policy = opf_policy_e'(mode_i);

    opf_tag_bits #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_blk  (acc_blk_i),
        .clr_en   (clr_en),
        .fill_en  (fill_valid_i),
        .fill_blk (fill_blk_i),
        .fill_pf  (fill_pf_i),
        .rd_bit   (tag_bit)
    );

    opf_policy #(.ADDR_W(ADDR_W)) u_policy (
        .policy    (policy),
        .acc_valid (acc_valid_i),
        .acc_hit   (acc_hit_i),
        .acc_blk   (acc_blk_i),
        .tag_bit   (tag_bit),
        .fire      (fire),
        .cand_blk  (cand_blk),
        .clr_en    (clr_en)
    );

    opf_req_fsm #(.ADDR_W(ADDR_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .load_blk (cand_blk),
        .ready    (pf_ready_i),
        .valid    (pf_valid_o),
        .blk      (pf_blk_o)
    );

endmodule

// File: tb/tb_opf_top.sv
`timescale 1ns/1ps
module tb_opf_top;
    localparam int AW   = 16;
    localparam int SW   = 4;
    localparam int SETS = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          acc_v = 1'b0;
    logic [AW-1:0] acc_b = '0;
    logic          acc_h = 1'b0;
    logic          fill_v = 1'b0;
    logic [AW-1:0] fill_b = '0;
    logic          fill_p = 1'b0;
    logic          rdy = 1'b0;
    logic          pf_v;
    logic [AW-1:0] pf_b;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit          m_flag [SETS];
    bit          m_v = 0;
    int unsigned m_b = 0;

    always #2.5 clk = ~clk;

    opf_top #(.ADDR_W(AW), .SET_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .acc_valid_i(acc_v), .acc_blk_i(acc_b), .acc_hit_i(acc_h),
        .fill_valid_i(fill_v), .fill_blk_i(fill_b), .fill_pf_i(fill_p),
        .pf_valid_o(pf_v), .pf_ready_i(rdy), .pf_blk_o(pf_b)
    );

    always @(posedge clk) begin
        int  idx;
        bit  trig;
        bit  clr;
        int unsigned cand;
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            m_v = 0;
            m_b = 0;
        end else begin
            trig = 0;
            clr  = 0;
            idx  = int'(acc_b) % SETS;
            cand = (int'(acc_b) + 1) % (1 << AW);
            if (acc_v) begin
                if (!mode) trig = !acc_h;
                else begin
                    trig = !acc_h || m_flag[idx];
                    clr  = acc_h && m_flag[idx];
                end
                if (int'(acc_b) == (1 << AW) - 1) trig = 0;
            end
            if (clr) m_flag[idx] = 0;
            if (fill_v) m_flag[int'(fill_b) % SETS] = fill_p;
            if (trig && !(m_v && m_b == cand)) begin
                m_v = 1;
                m_b = cand;
            end else if (m_v && rdy) begin
                m_v = 0;
            end
        end
        cycles++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pf_v !== m_v || (m_v && int'(pf_b) != m_b)) begin
                fails++;
                $display("FAIL %s model: got v=%0b b=%h exp v=%0b b=%h",
                         cur_req, pf_v, pf_b, m_v, m_b[AW-1:0]);
            end
        end
    end

    task automatic check(input string req, input bit ev, input int unsigned eb);
        checks++;
        if (pf_v !== ev || (ev && int'(pf_b) != eb)) begin
            fails++;
            $display("FAIL %s: got v=%0b b=%h exp v=%0b b=%h", req, pf_v, pf_b, ev, eb[AW-1:0]);
        end
    endtask

    task automatic idle();
        acc_v  = 0;
        fill_v = 0;
    endtask

    // One cycle of access, returns at the negedge after the sampling edge.
    task automatic acc(input int unsigned b, input bit hit);
        @(negedge clk);
        acc_v = 1; acc_b = b[AW-1:0]; acc_h = hit; fill_v = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic fill(input int unsigned b, input bit p);
        @(negedge clk);
        fill_v = 1; fill_b = b[AW-1:0]; fill_p = p; acc_v = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic drain();
        @(negedge clk);
        rdy = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", 0, 0);
        mode = 1; rdy = 1;
        acc(16'h0033, 1);
        check("R1", 0, 0);

        cur_req = "R2";
        mode = 0; rdy = 0;
        acc(16'h0010, 0);
        check("R2", 1, 16'h0011);
        drain(); rdy = 0;
        acc(16'h0020, 1);
        check("R2", 0, 0);

        cur_req = "R3";
        mode = 1;
        acc(16'h0040, 0);
        check("R3", 1, 16'h0041);
        drain(); rdy = 0;

        cur_req = "R6";
        fill(16'h0045, 1);
        cur_req = "R4";
        acc(16'h0105, 1);
        check("R4", 1, 16'h0106);
        drain(); rdy = 0;
        acc(16'h0105, 1);
        check("R4", 0, 0);

        cur_req = "R5";
        fill(16'h0047, 0);
        acc(16'h0047, 1);
        check("R5", 0, 0);

        cur_req = "R6";
        fill(16'h0048, 1);
        @(negedge clk);
        acc_v = 1; acc_b = 16'h0048; acc_h = 1;
        fill_v = 1; fill_b = 16'h0148; fill_p = 1;
        @(negedge clk);
        idle();
        check("R6", 1, 16'h0049);
        drain(); rdy = 0;
        acc(16'h0048, 1);
        check("R6", 1, 16'h0049);
        drain(); rdy = 0;
        fill(16'h0048, 0);
        acc(16'h0048, 1);
        check("R6", 0, 0);

        cur_req = "R7";
        mode = 0;
        acc(16'h0200, 0);
        repeat (3) @(negedge clk);
        check("R7", 1, 16'h0201);
        acc(16'h0300, 0);
        check("R7", 1, 16'h0301);

        cur_req = "R10";
        acc(16'h0300, 0);
        check("R10", 1, 16'h0301);
        @(negedge clk);
        rdy = 1; acc_v = 1; acc_b = 16'h0300; acc_h = 0;
        @(negedge clk);
        idle(); rdy = 0;
        check("R10", 0, 0);

        cur_req = "R8";
        acc(16'h0400, 0);
        @(negedge clk);
        rdy = 1;
        @(negedge clk);
        rdy = 0;
        check("R8", 0, 0);

        cur_req = "R9";
        acc(16'hFFFF, 0);
        check("R9", 0, 0);
        mode = 1;
        fill(16'h000F, 1);
        acc(16'hFFFF, 1);
        check("R9", 0, 0);
        acc(16'h001F, 1);
        check("R9", 0, 0);

        cur_req = "R7";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            acc_v  = (k % 3) != 0;
            acc_b  = AW'(k * 37 + 5);
            acc_h  = (k % 4) < 2;
            fill_v = (k % 5) == 1;
            fill_b = AW'(k * 11);
            fill_p = (k % 2) == 0;
            rdy    = (k % 7) > 3;
            mode   = (k / 10) % 2 == 1;
        end
        @(negedge clk);
        idle(); rdy = 1;
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule